// File: doc/BRIEF.md
# Fused Convolution and Max-Pool Engine

This engine computes one convolution layer of a small quantized CNN and pools its result 2x2 in the same pass. For every output channel and every pooling window it accumulates the four convolution results of that window one after another. Each result is requantized to signed 8 bits, and only the largest of the four is written out. The full convolution map is never stored, so the output activation buffer holds a quarter of what an unfused layer would need.

The engine reads input activations from one activation buffer through a synchronous read port. It writes pooled activations into a second buffer through a write port. Kernel weights and per-channel biases are fixed constants that the engine generates internally. A one-cycle `start` launches a pass over the whole layer, and a one-cycle `done` reports its end. The same engine, built with different parameters, serves both convolution layers of the network.

Top module: `fused_conv_pool`

## Requirements
- R1: After reset `done` and `out_we` are low. A `start` seen while idle begins one full pass. `done` is high for exactly one cycle, namely the cycle right after the final pooled write of the pass.
- R2: Input element (channel c, row y, column x) lives at `in_addr = (c*IN_H + y)*IN_W + x`. The buffer returns its value on `in_data` one cycle after the address is presented.
- R3: The weight of output channel o, input channel c and kernel tap (ky, kx) is `((5*o + 3*c + 7*ky + 2*kx) mod 11) - 3`. The bias of output channel o is `40*o - 20`.
- R4: Each convolution result is the bias plus the signed sum of products over all input channels and 5x5 taps, stride 1, no padding. A negative result is clamped to 0. The result is then shifted right by SHIFT, and anything above 127 becomes 127.
- R5: Pooled value (o, py, px) is the maximum of the four requantized results at convolution positions (2py+dy, 2px+dx), with dy and dx in {0,1}. A trailing convolution row or column that does not fill a whole window is dropped.
- R6: A pass writes exactly OUT_CH*PH*PW values, one per address `(o*PH + py)*PW + px`. All of them lie inside that range, and no two writes fall in adjacent cycles.
- R7: A `start` pulse that arrives while a pass is running has no effect. The running pass completes with its normal writes and a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches one layer pass when idle |
| done | output | 1 | One-cycle end-of-pass pulse |
| in_addr | output | AW | Input activation buffer read address |
| in_data | input | 8 | Signed input activation, one cycle after its address |
| out_we | output | 1 | Pooled activation write enable |
| out_addr | output | OAW | Pooled activation write address |
| out_data | output | 8 | Pooled signed activation |

## Verification
The bench builds the engine with a 9-wide, 8-high, two-channel input and two output channels, with SHIFT = 4. That gives a 5x4 convolution map, and its odd fifth column must be dropped by the pooling. Two input channels exercise the channel loop and the layout of the channel addresses. Two output channels give one negative and one positive bias, so the ReLU clamp and the bias path both show in an all-zero image. Uniform images of +127 and -128 drive the 8-bit saturation and the clamp to their limits. Two pseudo-random images check which quadrant wins each window's maximum.

// File: rtl/cpool_pkg.sv
// Shared types and constant functions for the fused convolution/pool engine.
// Assumes all index arguments are non-negative.
package cpool_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MAC,
        S_DRAIN,
        S_POOL,
        S_WRITE,
        S_FIN
    } cp_state_t;

    // Counter width for a count of n values, never below one bit.
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Fixed kernel weight for one tap, in the range -3..7.
    function automatic logic signed [7:0] tap_weight(input int oc, input int ic,
                                                     input int ky, input int kx);
        int t;
        t = ((oc * 5 + ic * 3 + ky * 7 + kx * 2) % 11) - 3;
        return 8'(t);
    endfunction

    // Fixed bias of one output channel.
    function automatic logic signed [31:0] chan_bias(input int oc);
        return 32'(oc * 40 - 20);
    endfunction

endpackage

// File: rtl/cpool_wrom.sv
// Constant weight and bias ROM, built as combinational logic from the tap
// indices. Assumes the indices stay inside the kernel and channel ranges.
module cpool_wrom
    import cpool_pkg::*;
#(
    parameter int OCW = 1,
    parameter int ICW = 1,
    parameter int KW  = 3
) (
    input  logic [OCW-1:0]     oc,
    input  logic [ICW-1:0]     ic,
    input  logic [KW-1:0]      ky,
    input  logic [KW-1:0]      kx,
    output logic signed [7:0]  weight,
    output logic signed [31:0] bias
);

    // Look up the tap weight and channel bias.
    always_comb begin
        weight = tap_weight(int'(oc), int'(ic), int'(ky), int'(kx));
        bias   = chan_bias(int'(oc));
    end

endmodule

// File: rtl/cpool_mac.sv
// Signed 8x8 multiply-accumulate into a 32-bit register.
// Assumes clear and en are never both needed in the same cycle (clear wins).
module cpool_mac (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               en,
    input  logic signed [7:0]  act,
    input  logic signed [7:0]  wgt,
    output logic signed [31:0] acc
);

    logic signed [15:0] prod;

    // Form the product of one tap.
    always_comb prod = act * wgt;

    // Accumulate products, or restart for a new convolution position.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else if (en)    acc <= acc + 32'(prod);
    end

endmodule

// File: rtl/cpool_pool.sv
// Requantizes a finished accumulator (bias, ReLU, shift, saturate) and keeps
// the running maximum over the four positions of one pool window.
// Assumes 'first' is asserted for the first position of each window.
module cpool_pool #(
    parameter int SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               first,
    input  logic signed [31:0] acc,
    input  logic signed [31:0] bias,
    output logic signed [7:0]  pmax
);

    logic signed [31:0] sum;
    logic signed [31:0] shf;
    logic signed [7:0]  q8;

    // Bias, clamp negatives to zero, shift, saturate to 127.
    always_comb begin
        sum = acc + bias;
        shf = (sum < 0) ? 32'sd0 : (sum >>> SHIFT);
        q8  = (shf > 32'sd127) ? 8'sd127 : shf[7:0];
    end

    // Load the first candidate of a window, then keep the larger one.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pmax <= '0;
        else if (en && (first || q8 > pmax)) pmax <= q8;
    end

endmodule

// File: rtl/fused_conv_pool.sv
// Fused convolution + 2x2/stride-2 max-pool layer engine. Walks output
// channel, pool row, pool column, window quadrant, then input channel and
// kernel taps; only pooled values leave the block. Assumes a synchronous
// input buffer with one cycle of read latency.
module fused_conv_pool
    import cpool_pkg::*;
#(
    parameter  int IN_W   = 12,
    parameter  int IN_H   = 12,
    parameter  int IN_CH  = 1,
    parameter  int OUT_CH = 2,
    parameter  int KSZ    = 5,
    parameter  int SHIFT  = 4,
    localparam int PH     = (IN_H - KSZ + 1) / 2,
    localparam int PW     = (IN_W - KSZ + 1) / 2,
    localparam int N_OUT  = OUT_CH * PH * PW,
    localparam int AW     = cnt_w(IN_CH * IN_H * IN_W),
    localparam int OAW    = cnt_w(N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic [AW-1:0]     in_addr,
    input  logic signed [7:0] in_data,
    output logic              out_we,
    output logic [OAW-1:0]    out_addr,
    output logic signed [7:0] out_data
);

    localparam int OCW = cnt_w(OUT_CH);
    localparam int ICW = cnt_w(IN_CH);
    localparam int YW  = cnt_w(PH);
    localparam int XW  = cnt_w(PW);
    localparam int KW  = cnt_w(KSZ);
    localparam logic [KW-1:0]  K_LAST  = KW'(KSZ - 1);
    localparam logic [ICW-1:0] IC_LAST = ICW'(IN_CH - 1);
    localparam logic [OCW-1:0] OC_LAST = OCW'(OUT_CH - 1);
    localparam logic [YW-1:0]  PY_LAST = YW'(PH - 1);
    localparam logic [XW-1:0]  PX_LAST = XW'(PW - 1);

    cp_state_t          state;
    logic [OCW-1:0]     oc_q;
    logic [YW-1:0]      py_q;
    logic [XW-1:0]      px_q;
    logic               qy_q, qx_q;
    logic [ICW-1:0]     ic_q;
    logic [KW-1:0]      ky_q, kx_q;
    logic               valid_d;
    logic signed [7:0]  w_d;
    logic signed [7:0]  w_cur;
    logic signed [31:0] b_cur;
    logic signed [31:0] acc;
    logic signed [7:0]  pmax;

    // Weight and bias for the tap currently addressed.
    cpool_wrom #(.OCW(OCW), .ICW(ICW), .KW(KW)) u_rom (
        .oc(oc_q), .ic(ic_q), .ky(ky_q), .kx(kx_q),
        .weight(w_cur), .bias(b_cur)
    );

    // Accumulator for one convolution position.
    cpool_mac u_mac (
        .clk(clk), .rst_n(rst_n),
        .clear(state == S_IDLE || state == S_POOL),
        .en(valid_d), .act(in_data), .wgt(w_d), .acc(acc)
    );

    // Requantize and keep the window maximum.
    cpool_pool #(.SHIFT(SHIFT)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .en(state == S_POOL), .first(!qy_q && !qx_q),
        .acc(acc), .bias(b_cur), .pmax(pmax)
    );

    // Input address of the current tap and output address of the window.
    always_comb begin
        in_addr  = AW'((32'(ic_q) * 32'(IN_H) + 32'(py_q) * 2 + 32'(qy_q) + 32'(ky_q))
                       * 32'(IN_W) + 32'(px_q) * 2 + 32'(qx_q) + 32'(kx_q));
        out_addr = OAW'((32'(oc_q) * 32'(PH) + 32'(py_q)) * 32'(PW) + 32'(px_q));
        out_we   = (state == S_WRITE);
        out_data = pmax;
        done     = (state == S_FIN);
    end

    // Align the weight with the read data returning one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_d <= 1'b0;
            w_d     <= '0;
        end else begin
            valid_d <= (state == S_MAC);
            w_d     <= w_cur;
        end
    end

    // Sequencer: loop counters and pass control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            oc_q <= '0; py_q <= '0; px_q <= '0;
            qy_q <= 1'b0; qx_q <= 1'b0;
            ic_q <= '0; ky_q <= '0; kx_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    oc_q <= '0; py_q <= '0; px_q <= '0;
                    qy_q <= 1'b0; qx_q <= 1'b0;
                    ic_q <= '0; ky_q <= '0; kx_q <= '0;
                    state <= S_MAC;
                end
                S_MAC: begin
                    if (kx_q == K_LAST) begin
                        kx_q <= '0;
                        if (ky_q == K_LAST) begin
                            ky_q <= '0;
                            if (ic_q == IC_LAST) begin
                                ic_q  <= '0;
                                state <= S_DRAIN;
                            end else begin
                                ic_q <= ic_q + 1'b1;
                            end
                        end else begin
                            ky_q <= ky_q + 1'b1;
                        end
                    end else begin
                        kx_q <= kx_q + 1'b1;
                    end
                end
                S_DRAIN: state <= S_POOL;
                S_POOL: begin
                    if (qx_q && qy_q) begin
                        qx_q  <= 1'b0;
                        qy_q  <= 1'b0;
                        state <= S_WRITE;
                    end else begin
                        if (qx_q) begin
                            qx_q <= 1'b0;
                            qy_q <= 1'b1;
                        end else begin
                            qx_q <= 1'b1;
                        end
                        state <= S_MAC;
                    end
                end
                S_WRITE: begin
                    state <= S_MAC;
                    if (px_q == PX_LAST) begin
                        px_q <= '0;
                        if (py_q == PY_LAST) begin
                            py_q <= '0;
                            if (oc_q == OC_LAST) begin
                                oc_q  <= '0;
                                state <= S_FIN;
                            end else begin
                                oc_q <= oc_q + 1'b1;
                            end
                        end else begin
                            py_q <= py_q + 1'b1;
                        end
                    end else begin
                        px_q <= px_q + 1'b1;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cpool_chk.sv
// Port-level protocol checks for fused_conv_pool, bound to every instance.
module cpool_chk #(
    parameter int N_OUT = 8,
    parameter int OAW   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              out_we,
    input logic [OAW-1:0]    out_addr,
    input logic signed [7:0] out_data
);

    // R1
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_we));

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (32'(out_addr) < N_OUT));

    // R6
    write_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> !out_we);

    // R4
    nonneg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> !out_data[7]);

endmodule

bind fused_conv_pool cpool_chk #(.N_OUT(N_OUT), .OAW(OAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .out_we(out_we),
    .out_addr(out_addr), .out_data(out_data)
);

// File: tb/fused_conv_pool_tb_top.sv
// Directed bench for fused_conv_pool: one task per scenario, each checking
// the pooled buffer contents and pass bookkeeping against a bench model.
module fused_conv_pool_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W   = 9;
    localparam int IN_H   = 8;
    localparam int IN_CH  = 2;
    localparam int OUT_CH = 2;
    localparam int SHIFT  = 4;
    localparam int PH     = (IN_H - 4) / 2;
    localparam int PW     = (IN_W - 4) / 2;
    localparam int N_OUT  = OUT_CH * PH * PW;
    localparam int DEPTH  = IN_CH * IN_H * IN_W;
    localparam int AW     = $clog2(DEPTH);
    localparam int OAW    = $clog2(N_OUT);
    localparam int WDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              done;
    logic [AW-1:0]     in_addr;
    logic signed [7:0] in_data;
    logic              out_we;
    logic [OAW-1:0]    out_addr;
    logic signed [7:0] out_data;

    int img [0:DEPTH-1];
    logic signed [7:0] res [0:N_OUT-1];
    int res_run [0:N_OUT-1];
    int run_id = 0;
    int wr_cnt = 0, done_cnt = 0, bad_cnt = 0;
    int cyc = 0, last_wr_cyc = -1, done_cyc = -1;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fused_conv_pool #(
        .IN_W(IN_W), .IN_H(IN_H), .IN_CH(IN_CH), .OUT_CH(OUT_CH), .SHIFT(SHIFT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .in_addr(in_addr), .in_data(in_data),
        .out_we(out_we), .out_addr(out_addr), .out_data(out_data)
    );

    // Input buffer with one cycle of read latency, output buffer and counters.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        in_data <= 8'(img[in_addr]);
        if (out_we) begin
            wr_cnt <= wr_cnt + 1;
            last_wr_cyc <= cyc;
            if (32'(out_addr) < N_OUT) begin
                res[out_addr] <= out_data;
                res_run[out_addr] <= run_id;
            end else begin
                bad_cnt <= bad_cnt + 1;
            end
        end
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_w(int o, int c, int ky, int kx);
        return ((5 * o + 3 * c + 7 * ky + 2 * kx) % 11) - 3;
    endfunction

    // Bench model of one pooled value (R3, R4, R5).
    function automatic int ref_pool(int o, int py, int px);
        int best = 0;
        for (int dy = 0; dy < 2; dy++)
            for (int dx = 0; dx < 2; dx++) begin
                int acc = 0;
                for (int c = 0; c < IN_CH; c++)
                    for (int ky = 0; ky < 5; ky++)
                        for (int kx = 0; kx < 5; kx++)
                            acc += img[(c * IN_H + 2 * py + dy + ky) * IN_W + 2 * px + dx + kx]
                                   * ref_w(o, c, ky, kx);
                acc = acc + 40 * o - 20;
                if (acc < 0) acc = 0;
                acc = acc >>> SHIFT;
                if (acc > 127) acc = 127;
                if (acc > best) best = acc;
            end
        return best;
    endfunction

    task automatic fill(input int mode);
        for (int i = 0; i < DEPTH; i++) begin
            case (mode)
                0: img[i] = 0;
                1: img[i] = 127;
                2: img[i] = -128;
                3: img[i] = ((i * 37 + 11) % 256) - 128;
                default: img[i] = ((i * 53 + 5) % 200) - 100;
            endcase
        end
    endtask

    // Run one pass, optionally with a second start mid-pass, and check it.
    task automatic run_pass(input string tag, input bit extra_start);
        int w0, d0, b0, t;
        @(negedge clk);
        run_id++;
        w0 = wr_cnt; d0 = done_cnt; b0 = bad_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        for (int o = 0; o < OUT_CH; o++)
            for (int py = 0; py < PH; py++)
                for (int px = 0; px < PW; px++) begin
                    int a = (o * PH + py) * PW + px;
                    check({tag, " R6 written this pass"}, res_run[a], run_id);
                    check({tag, " R5 pooled value"}, int'(res[a]), ref_pool(o, py, px));
                end
        check({tag, " R6 write count"}, wr_cnt - w0, N_OUT);
        check({tag, " R6 out-of-range writes"}, bad_cnt - b0, 0);
        check({tag, " R1 done pulses"}, done_cnt - d0, 1);
        check({tag, " R1 done one cycle after last write"}, done_cyc - last_wr_cyc, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done low in reset", int'(done), 0);
        check("R1 out_we low in reset", int'(out_we), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 done low while idle", int'(done), 0);
    endtask

    // R3: zero image leaves bias only; negative bias clamps, positive shifts.
    task automatic t_zero();
        fill(0);
        run_pass("zero image R3", 1'b0);
        check("R3 ch1 bias 20>>4", int'(res[PH * PW]), 1);
        check("R4 ch0 negative bias clamps", int'(res[0]), 0);
    endtask

    // R4: uniform extremes drive saturation and the ReLU clamp.
    task automatic t_extremes();
        fill(1);
        run_pass("all +127 R4", 1'b0);
        check("R4 saturates to 127", int'(res[0]), 127);
        fill(2);
        run_pass("all -128 R4", 1'b0);
        check("R4 negative clamps to 0", int'(res[0]), 0);
    endtask

    // R2, R5: varied image exercises addressing and window maximum.
    task automatic t_pattern();
        fill(3);
        run_pass("pattern R2", 1'b0);
    endtask

    // R7: a start during the pass changes nothing.
    task automatic t_restart();
        fill(4);
        run_pass("mid-pass start R7", 1'b1);
    endtask

    initial begin
        for (int i = 0; i < N_OUT; i++) res_run[i] = -1;
        fill(0);
        t_reset();
        t_zero();
        t_extremes();
        t_pattern();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", WDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule